// File: doc/BRIEF.md
# Pipeline Hazard Cycle Counter

This block estimates how many clock cycles a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) would need to run a stream of instructions. It does not run them. Each instruction arrives in program order as a one-cycle `in_valid` pulse. The pulse carries two source register numbers, a destination register number, and class flags for load, store, multiply and no-writeback. The block compares the sources with the results of the two previously accepted instructions. From that it computes the stall cycles the instruction would suffer, and it adds them to a running cycle total. It also counts the instructions.

Three static enables switch on three forwarding paths, each on its own:
- `en_mx`: from the memory-stage latch into execute.
- `en_wx`: from the writeback latch into execute.
- `en_wm`: from the writeback latch into the memory stage.

The register file is assumed to write in the first half of a cycle and read in the second half. Branches are treated as always predicted correctly, so only data dependences create stalls. Stalls from different instructions add, because the modelled machine is in order.

A typical use is a performance model placed beside a trace source. Software compares the totals under the eight bypass settings to judge what each forwarding path is worth.

Top module: `hazard_cycle_counter`

## Requirements
- R1: A synchronous reset sets `instr_count`, `cycle_count` and `last_stall` to 0 and forgets all earlier producers, so the first instruction after reset has 0 stalls.
- R2: On each cycle with `in_valid` high, `instr_count` grows by 1 and `cycle_count` grows by 1 plus that instruction's stall. `last_stall` then shows that stall. On cycles with `in_valid` low, none of the three outputs changes.
- R3: Only the two most recently accepted instructions can be producers, and for a given source the newest matching one wins. Register 0 never creates a dependence. An instruction with `is_store` or `no_wb` high never becomes a producer.
- R4: Each dependence needs a minimum issue spacing S between producer and consumer. The stall is max(0, S - distance), where distance is 1 for the previous instruction, and 2 plus the previous instruction's stall for the one before it. With no bypass enabled, S = 3.
- R5: With `en_mx` high, a result from a producer that is neither a load nor a multiply has S = 1, so it reaches the next instruction with 0 stalls.
- R6: With `en_wx` high, every non-multiply producer has S at most 2. A producer two back therefore costs 0, and a load followed at once by its consumer costs 1.
- R7: With `en_wm` high, the store data operand (`src_b` with `is_store` high) has S = 1 against any non-multiply producer. The store address operand (`src_a`) keeps the normal rules.
- R8: A multiply producer has S = 3 + MUL_EXTRA (default 7) with no bypass, or 2 + MUL_EXTRA (default 6) with `en_wx`. `en_mx` and `en_wm` do not shorten it. `last_stall` never exceeds MUL_EXTRA + 2.
- R9: An instruction's stall is the largest of its two operands' stalls, not their sum.
- R10: Fed from reset, the twelve-instruction multiply-accumulate loop body (compare, branch, load, multiply, load, add, store, four increments, jump) totals these cycles:
  - 23 with no bypass;
  - 19 with MX only;
  - 19 with WX only;
  - 21 with WM only;
  - 17 with all three paths enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One accepted instruction this cycle |
| src_a | input | 5 | First source register (store address) |
| src_b | input | 5 | Second source register (store data) |
| dst | input | 5 | Destination register |
| is_load | input | 1 | Instruction is a load |
| is_store | input | 1 | Instruction is a store |
| is_mul | input | 1 | Instruction is a multiply |
| no_wb | input | 1 | Instruction writes no register |
| en_mx | input | 1 | Enable memory-to-execute forwarding |
| en_wx | input | 1 | Enable writeback-to-execute forwarding |
| en_wm | input | 1 | Enable writeback-to-memory forwarding |
| instr_count | output | CNT_W | Accepted instruction total |
| cycle_count | output | CNT_W | Modelled cycle total |
| last_stall | output | STALL_W | Stall cycles of the latest instruction |

## Verification
The bound checker watches these rules on every cycle:
- the counter arithmetic: +1 for instructions, and +1 plus the reported stall for cycles;
- that both counters stay still on idle cycles;
- the zero-stall result for an instruction whose sources are both register 0, or which is the first after reset;
- the upper bound on any stall.

The dependence rules cannot be seen from the ports in a single cycle, because they depend on history. Only the bench scenarios show them: the spacing for each bypass path, the store data versus store address split, the multiply extension, a newer writer hiding an older one, and the previous stall shortening a two-back dependence. The bench checks these against its own scoreboard model and the hand-computed loop totals.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned REG_W = 5;
    localparam int unsigned HIST  = 2;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] dst;
        logic             ld;
        logic             mul;
    } prod_t;

endpackage

// File: rtl/hzd_latency.sv
// Minimum producer-to-consumer issue spacing for one producer slot.
module hzd_latency #(
    parameter int unsigned MUL_EXTRA = 4,
    parameter int unsigned LAT_W     = 3
) (
    input  logic             prod_ld,
    input  logic             prod_mul,
    input  logic             store_data,
    input  logic             en_mx,
    input  logic             en_wx,
    input  logic             en_wm,
    output logic [LAT_W-1:0] lat
);

    always_comb begin
        int unsigned sp;
        // Baseline: writeback-to-execute forwarding shortens the spacing by one slot.
        sp = en_wx ? 2 : 3;
        if (!prod_mul && ((en_mx && !prod_ld) || (en_wm && store_data))) begin
            sp = 1;
        end
        // A multiply holds the execute stage for MUL_EXTRA more cycles.
        if (prod_mul) begin
            sp = sp + MUL_EXTRA;
        end
        lat = LAT_W'(sp);
    end

endmodule

// File: rtl/hzd_operand.sv
// Stall demanded by one source operand against the producer history.
module hzd_operand
    import hzd_pkg::*;
#(
    parameter int unsigned MUL_EXTRA = 4,
    parameter int unsigned LAT_W     = 3,
    parameter int unsigned STALL_W   = 3
) (
    input  logic [REG_W-1:0]   src,
    input  logic               store_data,
    input  prod_t [HIST-1:0]   hist,
    input  logic [STALL_W-1:0] prev_stall,
    input  logic               en_mx,
    input  logic               en_wx,
    input  logic               en_wm,
    output logic [STALL_W-1:0] stall
);

    logic [LAT_W-1:0] lat [HIST];

    generate
        for (genvar g = 0; g < int'(HIST); g++) begin : g_lat
            hzd_latency #(
                .MUL_EXTRA(MUL_EXTRA),
                .LAT_W    (LAT_W)
            ) u_lat (
                .prod_ld   (hist[g].ld),
                .prod_mul  (hist[g].mul),
                .store_data(store_data),
                .en_mx     (en_mx),
                .en_wx     (en_wx),
                .en_wm     (en_wm),
                .lat       (lat[g])
            );
        end
    endgenerate

    always_comb begin
        logic found;
        int   gap;
        int   need;
        found = 1'b0;
        gap   = 0;
        need  = 0;
        stall = '0;
        // Slot 0 is the newest producer; the first match shadows older ones.
        for (int g = 0; g < int'(HIST); g++) begin
            if (!found && (src != '0) && hist[g].wr && (hist[g].dst == src)) begin
                found = 1'b1;
                gap   = g + 1 + ((g > 0) ? int'(prev_stall) : 0);
                need  = int'(lat[g]) - gap;
                if (need > 0) begin
                    stall = STALL_W'(need);
                end
            end
        end
    end

endmodule

// File: rtl/hazard_cycle_counter.sv
module hazard_cycle_counter
    import hzd_pkg::*;
#(
    parameter  int unsigned CNT_W     = 32,
    parameter  int unsigned MUL_EXTRA = 4,
    localparam int unsigned LAT_W     = $clog2(MUL_EXTRA + 4),
    localparam int unsigned STALL_W   = LAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [REG_W-1:0]   src_a,
    input  logic [REG_W-1:0]   src_b,
    input  logic [REG_W-1:0]   dst,
    input  logic               is_load,
    input  logic               is_store,
    input  logic               is_mul,
    input  logic               no_wb,
    input  logic               en_mx,
    input  logic               en_wx,
    input  logic               en_wm,
    output logic [CNT_W-1:0]   instr_count,
    output logic [CNT_W-1:0]   cycle_count,
    output logic [STALL_W-1:0] last_stall
);

    typedef struct packed {
        logic [CNT_W-1:0]   icnt;
        logic [CNT_W-1:0]   ccnt;
        logic [STALL_W-1:0] last;
        prod_t [HIST-1:0]   hist;
    } state_t;

    state_t st_d, st_q;

    logic [STALL_W-1:0] op_stall [2];
    logic [STALL_W-1:0] stall_now;

    generate
        for (genvar op = 0; op < 2; op++) begin : g_op
            logic [REG_W-1:0] op_src;
            logic             op_sdata;
            if (op == 0) begin : g_addr
                assign op_src   = src_a;
                assign op_sdata = 1'b0;
            end else begin : g_data
                assign op_src   = src_b;
                assign op_sdata = is_store;
            end
            hzd_operand #(
                .MUL_EXTRA(MUL_EXTRA),
                .LAT_W    (LAT_W),
                .STALL_W  (STALL_W)
            ) u_operand (
                .src       (op_src),
                .store_data(op_sdata),
                .hist      (st_q.hist),
                .prev_stall(st_q.last),
                .en_mx     (en_mx),
                .en_wx     (en_wx),
                .en_wm     (en_wm),
                .stall     (op_stall[op])
            );
        end
    endgenerate

    // Operand stalls overlap in time, so the larger one decides.
    assign stall_now = (op_stall[0] > op_stall[1]) ? op_stall[0] : op_stall[1];

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.icnt = st_q.icnt + CNT_W'(1);
            st_d.ccnt = st_q.ccnt + CNT_W'(1) + CNT_W'(stall_now);
            st_d.last = stall_now;
            for (int h = int'(HIST) - 1; h > 0; h--) begin
                st_d.hist[h] = st_q.hist[h-1];
            end
            st_d.hist[0].wr  = !no_wb && !is_store && (dst != '0);
            st_d.hist[0].dst = dst;
            st_d.hist[0].ld  = is_load;
            st_d.hist[0].mul = is_mul;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr_count = st_q.icnt;
    assign cycle_count = st_q.ccnt;
    assign last_stall  = st_q.last;

endmodule

// File: rtl/hazard_cycle_counter_chk.sv
module hazard_cycle_counter_chk #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned STALL_W   = 3,
    parameter int unsigned MUL_EXTRA = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [4:0]         src_a,
    input logic [4:0]         src_b,
    input logic [CNT_W-1:0]   instr_count,
    input logic [CNT_W-1:0]   cycle_count,
    input logic [STALL_W-1:0] last_stall
);

    AST_INSTR_STEP: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> instr_count == $past(instr_count) + CNT_W'(1)); // R2

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> cycle_count == $past(cycle_count) + CNT_W'(1) + CNT_W'(last_stall)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(instr_count) && $stable(cycle_count) && $stable(last_stall)); // R2

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_a == '0 && src_b == '0) |=> last_stall == '0); // R3

    AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && in_valid) |=> last_stall == '0); // R1

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(last_stall) <= int'(MUL_EXTRA) + 2); // R8

endmodule

bind hazard_cycle_counter hazard_cycle_counter_chk #(
    .CNT_W    (CNT_W),
    .STALL_W  (STALL_W),
    .MUL_EXTRA(MUL_EXTRA)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .src_a      (src_a),
    .src_b      (src_b),
    .instr_count(instr_count),
    .cycle_count(cycle_count),
    .last_stall (last_stall)
);

// File: tb/test_hazard_cycle_counter.sv
`timescale 1ns/1ps
module test_hazard_cycle_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  src_a = '0, src_b = '0, dst = '0;
    logic        is_load = 1'b0, is_store = 1'b0, is_mul = 1'b0, no_wb = 1'b0;
    logic        mx = 1'b0, wx = 1'b0, wm = 1'b0;
    logic [31:0] instr_count, cycle_count;
    logic [2:0]  last_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Scoreboard model: issue slot and class of the latest writer of each register.
    int          tp [32];
    int          wi [32];
    bit          pld [32];
    bit          pmul [32];
    int          slot;
    int          nidx;
    logic [31:0] exp_i, exp_c;
    int          exp_stall;

    always #10 clk = ~clk;

    hazard_cycle_counter i_hazard_cycle_counter (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .dst(dst),
        .is_load(is_load), .is_store(is_store), .is_mul(is_mul), .no_wb(no_wb),
        .en_mx(mx), .en_wx(wx), .en_wm(wm),
        .instr_count(instr_count), .cycle_count(cycle_count), .last_stall(last_stall)
    );

    task automatic check(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int spacing(input bit ld, input bit ml, input bit sdata);
        if (ml) return wx ? 6 : 7;
        if (wm && sdata) return 1;
        if (mx && !ld) return 1;
        return wx ? 2 : 3;
    endfunction

    task automatic model_clear();
        for (int r = 0; r < 32; r++) begin
            wi[r] = -10; tp[r] = 0; pld[r] = 0; pmul[r] = 0;
        end
        slot = 0; nidx = 0; exp_i = '0; exp_c = '0; exp_stall = 0;
    endtask

    task automatic do_reset(input bit m, input bit x, input bit w);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; mx = m; wx = x; wm = w;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic send(input int a, input int b, input int d,
                        input bit ld, input bit st, input bit ml, input bit nw,
                        input string req);
        int t_nom;
        int stl;
        t_nom = slot + 1;
        stl = 0;
        for (int op = 0; op < 2; op++) begin
            int r;
            r = (op == 0) ? a : b;
            if (r != 0 && wi[r] >= nidx - 2) begin
                int need;
                need = tp[r] + spacing(pld[r], pmul[r], (op == 1) && st) - t_nom;
                if (need > stl) stl = need;
            end
        end
        slot = t_nom + stl;
        if (!nw && !st && d != 0) begin
            tp[d] = slot; pld[d] = ld; pmul[d] = ml; wi[d] = nidx;
        end
        nidx++;
        exp_stall = stl;
        exp_i = exp_i + 32'd1;
        exp_c = exp_c + 32'd1 + 32'(stl);
        src_a = 5'(a); src_b = 5'(b); dst = 5'(d);
        is_load = ld; is_store = st; is_mul = ml; no_wb = nw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "stall", longint'(last_stall), longint'(exp_stall));
        check("R2", "instr_count", longint'(instr_count), longint'(exp_i));
        check("R2", "cycle_count", longint'(cycle_count), longint'(exp_c));
    endtask

    task automatic run_loop(input int total);
        send(5, 0, 6, 0, 0, 0, 0, "R4");  // compare
        send(6, 0, 0, 0, 0, 0, 1, "R5");  // branch
        send(1, 0, 7, 1, 0, 0, 0, "R6");  // load X
        send(7, 4, 8, 0, 0, 1, 0, "R6");  // multiply
        send(2, 0, 9, 1, 0, 0, 0, "R3");  // load Y
        send(8, 9, 10, 0, 0, 0, 0, "R9"); // add
        send(3, 10, 0, 0, 1, 0, 0, "R7"); // store
        send(1, 0, 1, 0, 0, 0, 0, "R3");
        send(2, 0, 2, 0, 0, 0, 0, "R3");
        send(3, 0, 3, 0, 0, 0, 0, "R3");
        send(5, 0, 5, 0, 0, 0, 0, "R3");
        send(0, 0, 0, 0, 0, 0, 1, "R3");  // jump
        check("R10", "loop total", longint'(cycle_count), longint'(total));
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(0, 0, 0);
        check("R1", "instr_count", longint'(instr_count), 0);
        check("R1", "cycle_count", longint'(cycle_count), 0);
        check("R1", "last_stall", longint'(last_stall), 0);

        // R10: hand-computed loop totals
        do_reset(0, 0, 0); run_loop(23);
        do_reset(1, 0, 0); run_loop(19);
        do_reset(0, 1, 0); run_loop(19);
        do_reset(0, 0, 1); run_loop(21);
        do_reset(1, 1, 1); run_loop(17);

        // R2: idle cycles change nothing
        @(negedge clk);
        check("R2", "idle instr_count", longint'(instr_count), longint'(exp_i));
        check("R2", "idle cycle_count", longint'(cycle_count), longint'(exp_c));
        check("R2", "idle last_stall", longint'(last_stall), 0);

        // R1: history forgotten across reset
        send(3, 0, 4, 0, 0, 0, 0, "R1");
        do_reset(0, 0, 0);
        send(4, 0, 5, 0, 0, 0, 0, "R1");
        check("R1", "fresh stall", longint'(last_stall), 0);

        // R3: newest writer shadows older; register 0; store makes no producer
        do_reset(0, 0, 0);
        send(0, 0, 1, 0, 0, 1, 0, "R3");  // multiply writes r1
        send(0, 0, 1, 0, 0, 0, 0, "R3");  // alu overwrites r1
        send(1, 0, 2, 0, 0, 0, 0, "R3");
        check("R3", "shadowed mul", longint'(last_stall), 2);
        send(0, 0, 0, 0, 0, 0, 0, "R3");  // writes r0
        send(0, 0, 3, 0, 0, 0, 0, "R3");
        check("R3", "r0 source", longint'(last_stall), 0);
        send(6, 0, 7, 0, 1, 0, 0, "R3");  // store naming r7 as dst
        send(7, 0, 8, 0, 0, 0, 0, "R3");
        check("R3", "store not producer", longint'(last_stall), 0);

        // R4/R9: previous stall widens the two-back distance
        do_reset(0, 0, 0);
        send(0, 0, 2, 0, 0, 0, 0, "R4");
        send(2, 0, 3, 0, 0, 0, 0, "R4");
        check("R4", "one back", longint'(last_stall), 2);
        send(2, 0, 4, 0, 0, 0, 0, "R9");
        check("R9", "two back after stall", longint'(last_stall), 0);
        send(0, 0, 5, 0, 0, 0, 0, "R4");
        send(0, 0, 6, 0, 0, 0, 0, "R4");
        send(5, 0, 7, 0, 0, 0, 0, "R4");
        check("R4", "two back", longint'(last_stall), 1);

        // R7: data operand forwarded, address operand not
        do_reset(0, 0, 1);
        send(0, 0, 4, 1, 0, 0, 0, "R7");
        send(6, 4, 0, 0, 1, 0, 0, "R7");
        check("R7", "store data from load", longint'(last_stall), 0);
        send(0, 0, 4, 1, 0, 0, 0, "R7");
        send(4, 6, 0, 0, 1, 0, 0, "R7");
        check("R7", "store address from load", longint'(last_stall), 2);

        // R8: multiply ignores MX
        do_reset(1, 0, 1);
        send(0, 0, 1, 0, 0, 1, 0, "R8");
        send(1, 0, 2, 0, 0, 0, 0, "R8");
        check("R8", "mul consumer", longint'(last_stall), 6);
        do_reset(1, 1, 0);
        send(0, 0, 1, 0, 0, 1, 0, "R8");
        send(1, 0, 2, 0, 0, 0, 0, "R8");
        check("R8", "mul consumer wx", longint'(last_stall), 5);

        // R5/R6: sweep of all eight bypass settings with dense random hazards
        for (int cfg = 0; cfg < 8; cfg++) begin
            do_reset(cfg[0], cfg[1], cfg[2]);
            for (int n = 0; n < 400; n++) begin
                int kind;
                kind = $urandom_range(0, 5);
                if ($urandom_range(0, 9) == 0) begin
                    @(negedge clk);
                    check("R2", "sweep idle", longint'(cycle_count), longint'(exp_c));
                end
                send($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                     kind == 1, kind == 2, kind == 3, kind == 4,
                     cfg[0] ? "R5" : "R6");
            end
        end

        done = 1;
        report();
        $finish;
    end

endmodule